// File: doc/BRIEF.md
# HDLC Frame Receiver with Tagged Byte Queue

This block takes a serial HDLC bit stream, one bit per cycle in which the bit enable is high. It finds the 0x7E delimiters, removes the zero inserted after every run of five ones, and packs the remaining bits into bytes, least significant bit first. It runs a CRC-16 over each frame. The payload bytes go into a byte queue. The two check-sequence bytes at the end of each frame are kept out of the queue. Each queue entry carries three tags: first byte of a frame, last byte of a frame, and last byte of a frame that arrived intact.

A host reads an 8-bit status word and pops bytes through a read strobe. The four upper status bits hold frame events until the host reads the status word. The four lower bits always show the current state: whether the queue is empty, and the tags of the byte now at the head. Because the tags follow the head, the host can find frame boundaries and frame quality one byte at a time while it drains the queue.

Top module: `hdlc_rx_tagged`

## Requirements
- R1: After reset the status word reads 0x08 (only the empty bit set) and the read data port reads 0x00.
- R2: Status bit layout: bit 7 abort, bit 6 check error, bit 5 overrun, bit 4 frame done, bit 3 empty, bit 2 head byte ends a good frame, bit 1 head byte ends a frame, bit 0 head byte starts a frame.
- R3: A received 0x7E pattern closes the open frame and opens the next frame. A zero that follows five ones is discarded. Data bytes are assembled LSB first, and only the payload enters the queue, without the two check bytes.
- R4: The check is CRC-16 with polynomial x^16+x^12+x^5+1, processed bit-reflected with a preset of 0xFFFF. It is computed over payload plus check bytes, and a good frame leaves the residue 0xF0B8. When a frame of at least four bytes closes, bit 4 sets. Bit 6 also sets if the residue is wrong or if the bit count between the flags is not a whole number of bytes.
- R5: A frame of fewer than four bytes between flags leaves no queue entry and sets no status bit. A four-byte frame stores its two payload bytes.
- R6: Seven consecutive ones set bit 7 and discard the open frame. No closing tag is written and bit 4 does not set. Reception resumes at the next flag.
- R7: The queue holds 64 entries. A byte that arrives while the queue is full is dropped and sets bit 5. The bytes already in the queue are kept.
- R8: Bits 7 to 4 are sticky. A status read strobe clears them at its clock edge. An event in the same cycle as the read strobe stays set.
- R9: Bit 3 is high exactly while the queue holds no entry.
- R10: Bits 2 to 0 show the tags of the head entry and read zero while the queue is empty. The first payload byte carries the start tag. The final payload byte carries the end tag, and it also carries the good tag only if the frame had a correct residue and no dropped byte.
- R11: The read data port shows the head byte. A read strobe removes that byte. A read strobe while the queue is empty returns 0x00 and changes nothing.
- R12: Cycles with the bit enable low are ignored whatever the line bit is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_en | input | 1 | Line bit qualifier |
| rx_bit | input | 1 | Serial line data |
| rd_stat | input | 1 | Status read strobe; clears the sticky bits |
| rd_data | input | 1 | Pop strobe for the head byte |
| stat | output | 8 | Status word |
| rd_byte | output | 8 | Head byte, zero when empty |

## Verification
The bench sends frames whose payload contains long runs of ones and the flag pattern itself. A receiver that failed to drop stuffed zeros, or that took a payload 0x7E for a delimiter, would queue the wrong bytes or cut the frame short. It also covers the two-payload-byte frame at the minimum length, a three-byte frame that must vanish without trace, a frame padded by a few bits, and an abort in the middle of a frame. A design that got the length threshold wrong, tested alignment badly or let an aborted frame through would show a wrong byte stream or wrong status bits. A queue overfilled by three long frames must keep exactly the first 64 bytes and report overrun. A read of the empty queue must change nothing, and gaps in the bit enable must have no effect. Errors in the full or empty bookkeeping, or in the tag placement, would show up as missing or shifted entries.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   localparam int BYTE_W = 8;
   localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
   localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
   localparam logic [15:0] CRC_POLY_R  = 16'h8408;

   typedef struct packed {
      logic first;
      logic last;
      logic good;
   } rx_tag_t;

   localparam int TAG_W = $bits(rx_tag_t);

   // bit-reflected CRC-16 over one byte, LSB first
   function automatic logic [15:0] crc_step_byte(input logic [15:0] c, input logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ b[i]) r = (r >> 1) ^ CRC_POLY_R;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/hdlc_rx_deframe.sv
module hdlc_rx_deframe #(
   parameter int STUFF_RUN = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic line_bit,
   output logic bit_ok,
   output logic bit_val,
   output logic flag_hit,
   output logic abort_hit
);
   localparam int FLAG_RUN  = STUFF_RUN + 1;
   localparam int ABORT_RUN = STUFF_RUN + 2;
   localparam int RUN_W     = $clog2(ABORT_RUN + 1);

   logic [RUN_W-1:0] run_q, run_d;

   assign bit_val = line_bit;

   always_comb begin
      run_d     = run_q;
      bit_ok    = 1'b0;
      flag_hit  = 1'b0;
      abort_hit = 1'b0;
      if (en) begin
         if (line_bit) begin
            bit_ok    = 1'b1;
            abort_hit = (run_q == RUN_W'(FLAG_RUN));
            if (run_q != RUN_W'(ABORT_RUN)) run_d = run_q + 1'b1;
         end else begin
            flag_hit = (run_q == RUN_W'(FLAG_RUN));
            bit_ok   = (run_q != RUN_W'(STUFF_RUN)) && (run_q != RUN_W'(FLAG_RUN));
            run_d    = '0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_d;
   end

endmodule

// File: rtl/hdlc_rx_framer.sv
module hdlc_rx_framer
   import hdlc_rx_pkg::*;
#(
   parameter int MIN_BYTES = 4,
   parameter int FCS_BYTES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_ok,
   input  logic              bit_val,
   input  logic              flag_hit,
   input  logic              abort_hit,
   input  logic              wr_drop,
   output logic              push_q,
   output logic [BYTE_W-1:0] push_byte_q,
   output rx_tag_t           push_tag_q,
   output logic              ev_vm_q,
   output logic              ev_crc_q,
   output logic              ev_abort_q
);
   localparam int HOLD  = FCS_BYTES + 1;
   localparam int CNT_W = $clog2(MIN_BYTES + 1);

   if (MIN_BYTES <= HOLD) begin : g_bad_min
      $error("MIN_BYTES must exceed FCS_BYTES + 1");
   end

   logic                        active_q;
   logic [BYTE_W-2:0]           sreg_q;
   logic [2:0]                  bcnt_q;
   logic [CNT_W-1:0]            cnt_q;
   logic [HOLD-1:0][BYTE_W-1:0] hold_q;
   logic [15:0]                 crc_q;
   logic                        first_pend_q;
   logic                        ovr_frame_q;
   logic [BYTE_W-1:0]           byte_nxt;
   logic                        crc_bad;

   assign byte_nxt = {bit_val, sreg_q};
   // aligned frame: the 7 flag bits before the closing zero leave bcnt at 7
   assign crc_bad  = (crc_q != CRC_RESIDUE) || (bcnt_q != 3'd7);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q     <= 1'b0;
         sreg_q       <= '0;
         bcnt_q       <= '0;
         cnt_q        <= '0;
         hold_q       <= '0;
         crc_q        <= CRC_PRESET;
         first_pend_q <= 1'b0;
         ovr_frame_q  <= 1'b0;
         push_q       <= 1'b0;
         push_byte_q  <= '0;
         push_tag_q   <= '0;
         ev_vm_q      <= 1'b0;
         ev_crc_q     <= 1'b0;
         ev_abort_q   <= 1'b0;
      end else begin
         push_q     <= 1'b0;
         ev_vm_q    <= 1'b0;
         ev_crc_q   <= 1'b0;
         ev_abort_q <= 1'b0;
         if (wr_drop) ovr_frame_q <= 1'b1;
         if (abort_hit) begin
            ev_abort_q <= 1'b1;
            active_q   <= 1'b0;
         end else if (flag_hit) begin
            if (active_q && (cnt_q >= CNT_W'(MIN_BYTES))) begin
               ev_vm_q          <= 1'b1;
               ev_crc_q         <= crc_bad;
               push_q           <= 1'b1;
               push_byte_q      <= hold_q[HOLD-1];
               push_tag_q.first <= first_pend_q;
               push_tag_q.last  <= 1'b1;
               push_tag_q.good  <= !crc_bad && !ovr_frame_q && !wr_drop;
            end
            active_q     <= 1'b1;
            bcnt_q       <= '0;
            cnt_q        <= '0;
            crc_q        <= CRC_PRESET;
            first_pend_q <= 1'b1;
            ovr_frame_q  <= 1'b0;
         end else if (bit_ok && active_q) begin
            sreg_q <= byte_nxt[BYTE_W-1:1];
            bcnt_q <= bcnt_q + 1'b1;
            if (bcnt_q == 3'd7) begin
               crc_q  <= crc_step_byte(crc_q, byte_nxt);
               hold_q <= {hold_q[HOLD-2:0], byte_nxt};
               if (cnt_q < CNT_W'(MIN_BYTES)) cnt_q <= cnt_q + 1'b1;
               if (cnt_q >= CNT_W'(HOLD)) begin
                  push_q       <= 1'b1;
                  push_byte_q  <= hold_q[HOLD-1];
                  push_tag_q   <= '{first: first_pend_q, last: 1'b0, good: 1'b0};
                  first_pend_q <= 1'b0;
               end
            end
         end
      end
   end

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo #(
   parameter int DEPTH  = 64,
   parameter int WORD_W = 11,
   localparam int AW    = $clog2(DEPTH),
   localparam int CW    = AW + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [WORD_W-1:0] wr_word,
   input  logic              rd_en,
   output logic [WORD_W-1:0] head_word,
   output logic              empty,
   output logic              drop,
   output logic [CW-1:0]     count
);
   if (DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be at least 2");
   end

   logic [WORD_W-1:0] mem [DEPTH];
   logic [AW-1:0]     wr_ptr, rd_ptr, wr_nxt, rd_nxt;
   logic [CW-1:0]     cnt_q;
   logic              full, do_wr, do_rd;

   if ((1 << AW) == DEPTH) begin : g_pow2
      assign wr_nxt = wr_ptr + 1'b1;
      assign rd_nxt = rd_ptr + 1'b1;
   end else begin : g_wrap
      assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
   end

   assign empty     = (cnt_q == '0);
   assign full      = (cnt_q == CW'(DEPTH));
   assign do_wr     = wr_en && !full;
   assign do_rd     = rd_en && !empty;
   assign drop      = wr_en && full;
   assign count     = cnt_q;
   assign head_word = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_nxt;
         if (do_rd) rd_ptr <= rd_nxt;
         case ({do_wr, do_rd})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

endmodule

// File: rtl/hdlc_rx_tagged.sv
module hdlc_rx_tagged
   import hdlc_rx_pkg::*;
#(
   parameter int DEPTH     = 64,
   parameter int STUFF_RUN = 5,
   parameter int MIN_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rx_en,
   input  logic       rx_bit,
   input  logic       rd_stat,
   input  logic       rd_data,
   output logic [7:0] stat,
   output logic [7:0] rd_byte
);
   localparam int WORD_W = BYTE_W + TAG_W;
   localparam int CW     = $clog2(DEPTH) + 1;

   logic              bit_ok, bit_val, flag_hit, abort_hit;
   logic              fifo_push, fifo_empty, ev_ovr;
   logic [BYTE_W-1:0] push_byte;
   rx_tag_t           push_tag, head_tag;
   logic              ev_vm, ev_crc, ev_abort;
   logic [WORD_W-1:0] head_word;
   logic [CW-1:0]     fifo_cnt;
   logic [3:0]        evt_q;

   hdlc_rx_deframe #(.STUFF_RUN(STUFF_RUN)) i_deframe (
      .clk(clk), .rst_n(rst_n), .en(rx_en), .line_bit(rx_bit),
      .bit_ok(bit_ok), .bit_val(bit_val), .flag_hit(flag_hit), .abort_hit(abort_hit)
   );

   hdlc_rx_framer #(.MIN_BYTES(MIN_BYTES), .FCS_BYTES(2)) i_framer (
      .clk(clk), .rst_n(rst_n), .bit_ok(bit_ok), .bit_val(bit_val),
      .flag_hit(flag_hit), .abort_hit(abort_hit), .wr_drop(ev_ovr),
      .push_q(fifo_push), .push_byte_q(push_byte), .push_tag_q(push_tag),
      .ev_vm_q(ev_vm), .ev_crc_q(ev_crc), .ev_abort_q(ev_abort)
   );

   hdlc_rx_fifo #(.DEPTH(DEPTH), .WORD_W(WORD_W)) i_fifo (
      .clk(clk), .rst_n(rst_n), .wr_en(fifo_push), .wr_word({push_tag, push_byte}),
      .rd_en(rd_data), .head_word(head_word), .empty(fifo_empty), .drop(ev_ovr),
      .count(fifo_cnt)
   );

   assign head_tag = rx_tag_t'(head_word[WORD_W-1:BYTE_W]);
   assign rd_byte  = fifo_empty ? '0 : head_word[BYTE_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) evt_q <= '0;
      else        evt_q <= (rd_stat ? 4'b0000 : evt_q) | {ev_abort, ev_crc, ev_ovr, ev_vm};
   end

   assign stat = {evt_q, fifo_empty,
                  !fifo_empty && head_tag.good,
                  !fifo_empty && head_tag.last,
                  !fifo_empty && head_tag.first};

endmodule

// File: rtl/hdlc_rx_chk.sv
module hdlc_rx_chk #(
   parameter int DEPTH = 64,
   localparam int CW   = $clog2(DEPTH) + 1
) (
   input logic          clk,
   input logic          rst_n,
   input logic          rd_stat,
   input logic          rd_data,
   input logic [7:0]    stat,
   input logic [CW-1:0] fifo_cnt,
   input logic          fifo_push,
   input logic          ev_abort
);
   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(DEPTH)); // R7
   AST_POK_IS_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      stat[2] |-> stat[1]); // R10
   AST_NOT_OPEN_AND_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
      !(stat[0] && stat[1])); // R5
   AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_stat && !ev_abort |=> !stat[7]); // R8
   AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      stat[7] && !rd_stat |=> stat[7]); // R8
   AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && stat[3] && !fifo_push |=> stat[3]); // R11
   AST_POP_DECREMENTS: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data && !stat[3] && !fifo_push |=> fifo_cnt == $past(fifo_cnt) - CW'(1)); // R11
endmodule

bind hdlc_rx_tagged hdlc_rx_chk #(.DEPTH(DEPTH)) i_chk (
   .clk(clk), .rst_n(rst_n), .rd_stat(rd_stat), .rd_data(rd_data), .stat(stat),
   .fifo_cnt(fifo_cnt), .fifo_push(fifo_push), .ev_abort(ev_abort)
);

// File: tb/test_hdlc_rx_tagged.sv
`timescale 1ns/1ps
module test_hdlc_rx_tagged;
   localparam int DEPTH = 64;

   typedef logic [7:0] bq_t [$];
   typedef struct {
      logic [7:0] d;
      logic f;
      logic l;
      logic g;
   } exp_t;

   logic clk = 1'b0;
   logic rst_n, rx_en, rx_bit, rd_stat, rd_data;
   logic [7:0] stat, rd_byte;

   always #2 clk = ~clk;

   hdlc_rx_tagged i_hdlc_rx_tagged (
      .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_bit(rx_bit),
      .rd_stat(rd_stat), .rd_data(rd_data), .stat(stat), .rd_byte(rd_byte)
   );

   exp_t exp_q[$];
   int   model_cnt = 0;
   int   checks = 0;
   int   errors = 0;
   int   ones_run = 0;
   bit   gap_mode = 0;
   bit   done = 0;

   task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] expv);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   task automatic send_bit(input logic b);
      @(negedge clk);
      rx_en  = 1'b1;
      rx_bit = b;
      @(negedge clk);
      rx_en  = 1'b0;
      rx_bit = 1'($urandom_range(0, 1));
      if (gap_mode) repeat (2) @(negedge clk);
   endtask

   task automatic send_flag();
      send_bit(1'b0);
      repeat (6) send_bit(1'b1);
      send_bit(1'b0);
      ones_run = 0;
   endtask

   task automatic send_byte(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         send_bit(v[i]);
         if (v[i]) ones_run++; else ones_run = 0;
         if (ones_run == 5) begin
            send_bit(1'b0);
            ones_run = 0;
         end
      end
   endtask

   function automatic logic [15:0] fcs_of(input bq_t q);
      logic [15:0] c = 16'hFFFF;
      foreach (q[k]) begin
         for (int i = 0; i < 8; i++) begin
            logic fb = c[0] ^ q[k][i];
            c = c >> 1;
            if (fb) c = c ^ 16'h8408;
         end
      end
      return ~c;
   endfunction

   // sends payload, check bytes, optional pad bits and the closing flag
   task automatic send_frame(input bq_t q, input bit bad, input int pad);
      logic [15:0] fcs = fcs_of(q);
      if (bad) fcs = fcs ^ 16'h0001;
      foreach (q[k]) send_byte(q[k]);
      send_byte(fcs[7:0]);
      send_byte(fcs[15:8]);
      for (int i = 0; i < pad; i++) send_bit(1'b0);
      send_flag();
      if (q.size() + 2 >= 4 && pad == 0) begin
         foreach (q[k]) begin
            if (model_cnt < DEPTH) begin
               exp_q.push_back('{d: q[k], f: (k == 0), l: (k == q.size() - 1),
                                 g: (k == q.size() - 1) && !bad});
               model_cnt++;
            end
         end
      end
      repeat (6) @(negedge clk);
   endtask

   task automatic read_status(output logic [7:0] s);
      @(negedge clk);
      s       = stat;
      rd_stat = 1'b1;
      @(negedge clk);
      rd_stat = 1'b0;
   endtask

   // monitor: pops head entries and compares against the scoreboard
   task automatic drain(input bit cmp, input string req);
      exp_t e;
      @(negedge clk);
      while (!stat[3]) begin
         if (cmp) begin
            if (exp_q.size() == 0) begin
               chk(req, "unexpected entry", {8'h0, rd_byte}, 16'hFFFF);
            end else begin
               e = exp_q.pop_front();
               chk(req, "data", {8'h0, rd_byte}, {8'h0, e.d});
               chk("R10", "tags", {13'h0, stat[2:0]}, {13'h0, e.g, e.l, e.f});
            end
         end
         rd_data = 1'b1;
         @(negedge clk);
         rd_data = 1'b0;
      end
      if (cmp) chk(req, "entries missing", 16'(exp_q.size()), 16'h0);
      exp_q.delete();
      model_cnt = 0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [7:0] s;
      bq_t q;
      rst_n = 1'b0; rx_en = 1'b0; rx_bit = 1'b0; rd_stat = 1'b0; rd_data = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "reset status", {8'h0, stat}, 16'h0008);
      chk("R1", "reset data", {8'h0, rd_byte}, 16'h0000);

      send_flag();

      // basic frame
      q = '{8'h11, 8'h22, 8'h33};
      send_frame(q, 0, 0);
      read_status(s);
      chk("R2/R4", "sticky after good frame", {12'h0, s[7:4]}, 16'h1);
      chk("R9", "not empty", {15'h0, s[3]}, 16'h0);
      chk("R10", "head opening", {15'h0, s[0]}, 16'h1);
      read_status(s);
      chk("R8", "cleared by read", {12'h0, s[7:4]}, 16'h0);
      drain(1, "R3");

      // stuffing-heavy payload
      q = '{8'hFF, 8'h7E, 8'h3E, 8'hFC, 8'h1F, 8'hF8};
      send_frame(q, 0, 0);
      read_status(s);
      chk("R3", "stuffed frame status", {12'h0, s[7:4]}, 16'h1);
      drain(1, "R3");

      // bad check sequence
      q = '{8'h44, 8'h55, 8'h66, 8'h77};
      send_frame(q, 1, 0);
      read_status(s);
      chk("R4", "crc error status", {12'h0, s[7:4]}, 16'h5);
      drain(1, "R4");

      // too short
      q = '{8'hC3};
      send_frame(q, 0, 0);
      read_status(s);
      chk("R5", "short frame status", {12'h0, s[7:4]}, 16'h0);
      chk("R5", "short frame not stored", {15'h0, s[3]}, 16'h1);

      // minimum length
      q = '{8'hA5, 8'h5A};
      send_frame(q, 0, 0);
      read_status(s);
      chk("R5", "min frame status", {12'h0, s[7:4]}, 16'h1);
      drain(1, "R5");

      // back-to-back frames sharing flags
      q = '{8'h01, 8'h02};
      send_frame(q, 0, 0);
      q = '{8'h03, 8'h04, 8'h05};
      send_frame(q, 0, 0);
      drain(1, "R3");
      read_status(s);

      // abort mid-frame
      send_byte(8'h12);
      send_byte(8'h34);
      repeat (7) send_bit(1'b1);
      send_flag();
      repeat (6) @(negedge clk);
      read_status(s);
      chk("R6", "abort status", {12'h0, s[7:4]}, 16'h8);
      chk("R6", "aborted bytes absent", {15'h0, s[3]}, 16'h1);
      read_status(s);
      chk("R8", "abort cleared", {12'h0, s[7:4]}, 16'h0);
      q = '{8'h9A, 8'hBC};
      send_frame(q, 0, 0);
      drain(1, "R6");
      read_status(s);

      // non-aligned frame
      q = '{8'hDE, 8'hAD, 8'hBE, 8'hEF};
      send_frame(q, 0, 3);
      read_status(s);
      chk("R4", "misaligned status", {12'h0, s[7:4]}, 16'h5);
      drain(0, "R4");

      // enable gaps with line noise
      gap_mode = 1;
      q = '{8'h0F, 8'hF0, 8'h55};
      send_frame(q, 0, 0);
      gap_mode = 0;
      read_status(s);
      chk("R12", "gapped frame status", {12'h0, s[7:4]}, 16'h1);
      drain(1, "R12");

      // read while empty
      @(negedge clk);
      chk("R11", "empty status", {8'h0, stat}, 16'h0008);
      rd_data = 1'b1;
      @(negedge clk);
      rd_data = 1'b0;
      chk("R11", "empty read data", {8'h0, rd_byte}, 16'h0000);
      chk("R11", "empty read status", {8'h0, stat}, 16'h0008);
      q = '{8'h61, 8'h62};
      send_frame(q, 0, 0);
      drain(1, "R11");
      read_status(s);

      // overrun
      for (int f = 0; f < 3; f++) begin
         q.delete();
         for (int i = 0; i < 30; i++) q.push_back(8'(f * 30 + i + 1));
         send_frame(q, 0, 0);
      end
      read_status(s);
      chk("R7", "overrun bit", {15'h0, s[5]}, 16'h1);
      chk("R7", "frame done bit", {15'h0, s[4]}, 16'h1);
      chk("R7", "no crc error", {15'h0, s[6]}, 16'h0);
      drain(1, "R7");
      @(negedge clk);
      chk("R9", "empty after drain", {8'h0, stat}, 16'h0008);

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule